// File: doc/BRIEF.md
# Watchdog Timer with Protected Rate Select

This block is a computer-operating-properly watchdog. The bus clock drives a fixed power-of-two prescaler of `PRE_W` bits. A second divider stage, set by a 2-bit rate field, divides that tick stream again. A time-out counter then counts the second-stage ticks. If software does not service the watchdog before the counter expires, the block raises a reset request for one bus cycle. It then starts counting again from zero. The system reset that this request triggers is produced elsewhere.

To service the watchdog, software writes the arming value 0x55 and then the firing value 0xAA to the service port. Only that ordered pair restarts the count. The rate field comes up at its fastest setting. It can be changed once, and only during a short window after reset. After that the time-out period cannot be changed until the next reset. An enable input holds the whole timer at zero while it is low.

Top module: `cop_watchdog`

## Requirements
- R1: While `rst_n` is low, `rst_req` is low. After `rst_n` rises, the rate field holds code 00.
- R2: The time-out period, in bus cycles, is 2^PRE_W × F × TOUT_TICKS. F is set by the rate field: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64. Counting starts at the first edge after reset release. For example, the first request is high after edge 2^PRE_W × TOUT_TICKS at code 00.
- R3: Each reset request is exactly one cycle wide. The request clears all counters, so, without service, requests repeat once every period.
- R4: A rate write is accepted only at edges 1 to LOCK_CYC after reset release. A write at any later edge leaves the rate unchanged.
- R5: Only the first accepted rate write takes effect. Later writes, even inside the window, are ignored.
- R6: A write of 0xAA to the service port restarts the count if 0x55 was written before it. The next request then comes one full period after the edge that took the 0xAA.
- R7: A write of 0xAA that has no 0x55 before it has no effect. Service writes of any value other than 0x55 or 0xAA are ignored and do not cancel an earlier 0x55.
- R8: A completed service sequence in the cycle where the time-out would fire takes priority. No request is raised, and the count restarts.
- R9: While `wd_en` is low, no request is raised and all counts are held at zero. If `wd_en` is first sampled high at edge k, the first request comes at edge k−1 plus one period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wd_en | input | 1 | Watchdog enable; low holds the timer at zero |
| svc_we | input | 1 | Service write strobe |
| svc_data | input | 8 | Service write value (0x55 arms, 0xAA fires) |
| rate_we | input | 1 | Rate field write strobe |
| rate_data | input | 2 | Rate field write value |
| rst_req | output | 1 | One-cycle reset request on time-out |

## Verification
Every result is a count of edges from a reference edge. For reset release, the reference is edge 0. For a restart by enable, it is the enable edge minus one. For a completed service, it is the edge that took the 0xAA. The request goes high exactly one period after the reference edge and is low again one edge later. The bench numbers edges with its own counter, which restarts at reset. It records the edge number of every request by sampling one time unit after each rising edge. Each check then compares the recorded edge numbers with periods computed from the rate factors and the small parameter set that the bench uses.

// File: rtl/cop_pkg.sv
// Shared definitions for the watchdog: the rate codes, the service values
// and the limit of the second-stage divider for each rate.
package cop_pkg;

    // Rate codes; the value is the field the software writes
    typedef enum logic [1:0] {
        RATE_X1  = 2'b00,
        RATE_X4  = 2'b01,
        RATE_X16 = 2'b10,
        RATE_X64 = 2'b11
    } cop_rate_e;

    // Width of the second-stage divider (largest factor is 64)
    localparam int DIV_W = 6;

    // Service sequence values
    localparam logic [7:0] SVC_ARM  = 8'h55;
    localparam logic [7:0] SVC_FIRE = 8'hAA;

    // Last count of the second stage for a given rate (factor minus one)
    function automatic logic [DIV_W-1:0] rate_last(input cop_rate_e r);
        logic [DIV_W-1:0] v;
        case (r)
            RATE_X1:  v = DIV_W'(0);
            RATE_X4:  v = DIV_W'(3);
            RATE_X16: v = DIV_W'(15);
            default:  v = DIV_W'(63);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cop_prescaler.sv
// First divider stage: a free-running binary counter of PRE_W bits.
// It emits one tick every 2^PRE_W bus cycles, in the cycle where the
// counter holds all ones.
// Assumes: clr is a synchronous request to restart at zero, and it
// takes priority over counting.
module cop_prescaler #(
    parameter int PRE_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    logic [PRE_W-1:0] pre_cnt;

    // Count bus cycles; restart on reset or on a clear request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Tick when the counter is about to wrap
    always_comb begin
        tick = &pre_cnt;
    end

endmodule

// File: rtl/cop_rate_ctrl.sv
// Holds the time-protected rate field.
// The field resets to the fastest code. A single write is accepted while
// the window counter shows that fewer than LOCK_CYC edges have passed
// since reset release. After the first accepted write, or once the window
// has closed, the field is frozen until the next reset.
// Assumes: rst_n is synchronous and active low.
module cop_rate_ctrl
    import cop_pkg::*;
#(
    parameter int LOCK_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rate_we,
    input  logic [1:0] rate_data,
    output cop_rate_e  rate
);

    localparam int WIN_W = $clog2(LOCK_CYC + 1);

    logic [WIN_W-1:0] win_cnt;
    logic             written;
    logic             win_open;
    logic             accept;
    cop_rate_e        rate_q;

    // Window is open while fewer than LOCK_CYC edges have elapsed
    always_comb begin
        win_open = (win_cnt < WIN_W'(LOCK_CYC));
        accept   = rate_we && win_open && !written;
    end

    // Count edges since reset release, saturating at the window length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (win_open) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    // Capture the first accepted write and record that it happened
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q  <= RATE_X1;
            written <= 1'b0;
        end else if (accept) begin
            rate_q  <= cop_rate_e'(rate_data);
            written <= 1'b1;
        end
    end

    // Drive the selected rate out to the divider
    always_comb begin
        rate = rate_q;
    end

    // R5: once a write has landed, the field never changes again
    a_r5_rate_write_once: assert property (@(posedge clk) disable iff (!rst_n)
        written |=> $stable(rate_q));

    // R4: after the window closes, the field never changes again
    a_r4_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(rate_q));

endmodule

// File: rtl/cop_stage2.sv
// Second divider stage. It counts prescaler ticks and emits one stage
// tick every F prescaler ticks, where F is set by the rate field.
// The divider wraps with a >= compare, so a rate change in the middle of
// a count cannot make it run past its new limit.
// Assumes: clr restarts the stage at zero and takes priority.
module cop_stage2
    import cop_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      pre_tick,
    input  cop_rate_e rate,
    output logic      stage_tick
);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;
    logic             at_last;

    // Look up the last count for the current rate
    always_comb begin
        div_last   = rate_last(rate);
        at_last    = (div_cnt >= div_last);
        stage_tick = pre_tick && at_last;
    end

    // Advance on each prescaler tick; wrap at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_cnt <= '0;
        end else if (pre_tick) begin
            if (at_last) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // R2: a stage tick can only come with a prescaler tick
    a_r2_stage_follows_pre: assert property (@(posedge clk) disable iff (!rst_n)
        stage_tick |-> pre_tick);

endmodule

// File: rtl/cop_service.sv
// Service sequence detector. A write of the arming value arms it. A later
// write of the firing value, while armed, produces a one-cycle clear and
// disarms it. The firing value with no arming value before it does
// nothing. Other values are ignored and leave the armed state alone.
// Assumes: while the watchdog is disabled, service writes are ignored and
// the detector stays disarmed.
module cop_service
    import cop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    output logic       svc_clear
);

    logic armed;
    logic is_arm;
    logic is_fire;

    // Decode the service value
    always_comb begin
        is_arm    = svc_we && (svc_data == SVC_ARM);
        is_fire   = svc_we && (svc_data == SVC_FIRE);
        svc_clear = en && is_fire && armed;
    end

    // Track whether the arming value has been written
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            armed <= 1'b0;
        end else if (is_arm) begin
            armed <= 1'b1;
        end else if (svc_clear) begin
            armed <= 1'b0;
        end
    end

    // R6: a completed sequence leaves the detector disarmed
    a_r6_disarm_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        svc_clear |=> !armed);

    // R7: the firing value never clears while disarmed
    a_r7_fire_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_clear && $past(rst_n)) |-> $past(armed || is_arm));

endmodule

// File: rtl/cop_timeout.sv
// Time-out counter and reset-request register. The counter counts stage
// ticks. When the last tick of the period arrives, a one-cycle request is
// registered and a clear goes to every counter. A service clear
// in the same cycle cancels the request. A low enable holds everything
// at zero.
// Assumes: stage_tick comes straight from the divider and is one cycle wide.
module cop_timeout #(
    parameter int TOUT_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic svc_clear,
    input  logic stage_tick,
    output logic clr_all,
    output logic rst_req
);

    localparam int TCNT_W = (TOUT_TICKS > 1) ? $clog2(TOUT_TICKS) : 1;
    localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(TOUT_TICKS - 1);

    logic [TCNT_W-1:0] tcnt;
    logic              fire;

    // Decide on expiry and the shared clear
    always_comb begin
        fire    = en && !svc_clear && stage_tick && (tcnt == TCNT_LAST);
        clr_all = !en || svc_clear || fire;
    end

    // Count stage ticks until expiry or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            tcnt <= '0;
        end else if (stage_tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Register the request so it lasts exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= fire;
        end
    end

    // R3: the request is never longer than one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9: a low enable suppresses the request
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rst_req);

    // R8: a service clear in the expiry cycle wins
    a_r8_service_wins: assert property (@(posedge clk) disable iff (!rst_n)
        svc_clear |=> !rst_req);

    // R6: a service clear restarts the tick count
    a_r6_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        svc_clear |=> (tcnt == '0));

endmodule

// File: rtl/cop_watchdog.sv
// Top-level watchdog. The chain is: fixed prescaler, then the rate-selected
// second stage, then the time-out counter with the request register. A
// service detector and the protected rate field sit beside the chain. All
// counters share one clear: a low enable, a completed service, or expiry.
// Assumes: a single bus clock and a synchronous active-low reset.
module cop_watchdog
    import cop_pkg::*;
#(
    parameter int PRE_W      = 15,
    parameter int TOUT_TICKS = 1,
    parameter int LOCK_CYC   = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_en,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    input  logic       rate_we,
    input  logic [1:0] rate_data,
    output logic       rst_req
);

    logic      pre_tick;
    logic      stage_tick;
    logic      svc_clear;
    logic      clr_all;
    cop_rate_e rate;

    cop_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .tick  (pre_tick)
    );

    cop_rate_ctrl #(
        .LOCK_CYC (LOCK_CYC)
    ) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_we   (rate_we),
        .rate_data (rate_data),
        .rate      (rate)
    );

    cop_stage2 u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_all),
        .pre_tick   (pre_tick),
        .rate       (rate),
        .stage_tick (stage_tick)
    );

    cop_service u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (wd_en),
        .svc_we    (svc_we),
        .svc_data  (svc_data),
        .svc_clear (svc_clear)
    );

    cop_timeout #(
        .TOUT_TICKS (TOUT_TICKS)
    ) u_tout (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (wd_en),
        .svc_clear  (svc_clear),
        .stage_tick (stage_tick),
        .clr_all    (clr_all),
        .rst_req    (rst_req)
    );

    // R1: the request register is low in the cycle after reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !rst_req);

endmodule

// File: tb/cop_watchdog_tb.sv
// Bench for cop_watchdog. It uses a small prescaler and a short time-out
// so that every rate, the lock window edges and the service orderings can
// all be swept. Request edge numbers are counted from reset release.
module cop_watchdog_tb;

    localparam int PRE_W      = 2;
    localparam int TOUT_TICKS = 4;
    localparam int LOCK_CYC   = 64;
    localparam int BASE       = (1 << PRE_W) * TOUT_TICKS; // period at F=1

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_en = 1'b0;
    logic       svc_we = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       rate_we = 1'b0;
    logic [1:0] rate_data = 2'b00;
    logic       rst_req;

    int total = 0;
    int bad   = 0;
    int ecount = 0;
    int npulse = 0;
    int pulse_edge [0:15];
    int hi_run = 0;
    int max_run = 0;

    cop_watchdog #(
        .PRE_W      (PRE_W),
        .TOUT_TICKS (TOUT_TICKS),
        .LOCK_CYC   (LOCK_CYC)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_en     (wd_en),
        .svc_we    (svc_we),
        .svc_data  (svc_data),
        .rate_we   (rate_we),
        .rate_data (rate_data),
        .rst_req   (rst_req)
    );

    always #10 clk = ~clk; // 50 MHz

    // Edge numbering: edge 1 is the first edge with reset released
    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    // Record request edges and the longest run of high samples
    always @(posedge clk) begin
        #1;
        if (rst_req) begin
            if (npulse < 16) pulse_edge[npulse] = ecount;
            npulse = npulse + 1;
            hi_run = hi_run + 1;
            if (hi_run > max_run) max_run = hi_run;
        end else begin
            hi_run = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int factor(input int code);
        return 1 << (2 * code);
    endfunction

    // Apply reset and release it; returns at a negedge with ecount == 0
    task automatic do_reset(input logic en);
        @(negedge clk);
        rst_n = 1'b0;
        wd_en = en;
        svc_we = 1'b0;
        rate_we = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 request low in reset", int'(rst_req), 0);
        npulse = 0;
        max_run = 0;
        hi_run = 0;
        rst_n = 1'b1;
    endtask

    // Wait at negedges until edge number k has been taken
    task automatic run_to(input int k);
        while (ecount < k) @(negedge clk);
    endtask

    // Present a service write that is taken at edge k
    task automatic svc_at(input int k, input logic [7:0] v);
        run_to(k - 1);
        svc_we = 1'b1;
        svc_data = v;
        @(negedge clk);
        svc_we = 1'b0;
    endtask

    // Present a rate write that is taken at edge k
    task automatic rate_at(input int k, input logic [1:0] v);
        run_to(k - 1);
        rate_we = 1'b1;
        rate_data = v;
        @(negedge clk);
        rate_we = 1'b0;
    endtask

    // Watchdog for a hung run
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", ecount);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: default code 00 gives the shortest period
        do_reset(1'b1);
        run_to(2 * BASE + 2);
        chk("R1 default first request", pulse_edge[0], BASE);
        chk("R1 default second request", pulse_edge[1], 2 * BASE);
        chk("R3 request width", max_run, 1);

        // R2: sweep all rate codes, written at edge 1
        for (int r = 0; r < 4; r++) begin
            do_reset(1'b1);
            rate_at(1, 2'(r));
            run_to(2 * BASE * factor(r) + 2);
            chk($sformatf("R2 rate %0d first request", r), pulse_edge[0], BASE * factor(r));
            chk($sformatf("R3 rate %0d repeat period", r),
                pulse_edge[1] - pulse_edge[0], BASE * factor(r));
            chk($sformatf("R3 rate %0d width", r), max_run, 1);
        end

        // R4: a write at the last window edge is accepted
        do_reset(1'b1);
        rate_at(LOCK_CYC, 2'd3);
        run_to(LOCK_CYC + BASE * 64 + 2);
        chk("R4 last window edge accepted", pulse_edge[4] - pulse_edge[3], BASE * 64);

        // R4: a write one edge later is ignored
        do_reset(1'b1);
        rate_at(LOCK_CYC + 1, 2'd3);
        run_to(LOCK_CYC + 4 * BASE);
        chk("R4 late write ignored", pulse_edge[5] - pulse_edge[4], BASE);

        // R5: the second write inside the window is ignored
        do_reset(1'b1);
        rate_at(2, 2'd1);
        rate_at(5, 2'd3);
        run_to(2 * BASE * 4 + 2);
        chk("R5 second write ignored first", pulse_edge[0], BASE * 4);
        chk("R5 second write ignored period", pulse_edge[1], 2 * BASE * 4);

        // R6: regular service keeps the request away
        do_reset(1'b1);
        for (int e = 5; e < 100; e += 10) begin
            svc_at(e, 8'h55);
            svc_at(e + 1, 8'hAA);
        end
        run_to(96 + BASE + 2);
        chk("R6 no request while serviced", (npulse > 0) ? pulse_edge[0] : 0, 96 + BASE);
        chk("R6 one request after service stops", npulse, 1);

        // R7: firing value alone does nothing
        do_reset(1'b1);
        svc_at(10, 8'hAA);
        run_to(BASE + 2);
        chk("R7 lone fire no effect", pulse_edge[0], BASE);

        // R7: other values do not cancel the arming value
        do_reset(1'b1);
        svc_at(5, 8'h55);
        svc_at(6, 8'h12);
        svc_at(8, 8'h00);
        svc_at(10, 8'hAA);
        run_to(10 + BASE + 2);
        chk("R7 stray values ignored", pulse_edge[0], 10 + BASE);

        // R7: other values alone do not restart the count
        do_reset(1'b1);
        svc_at(4, 8'h5A);
        svc_at(7, 8'hA5);
        run_to(BASE + 2);
        chk("R7 stray values alone", pulse_edge[0], BASE);

        // R8: service completed in the expiry cycle wins
        do_reset(1'b1);
        svc_at(3, 8'h55);
        svc_at(BASE, 8'hAA);
        run_to(2 * BASE + 2);
        chk("R8 service beats expiry", pulse_edge[0], 2 * BASE);

        // R9: disabled watchdog stays quiet, then restarts a full period
        do_reset(1'b0);
        svc_at(20, 8'h55);
        svc_at(21, 8'hAA);
        run_to(200);
        chk("R9 quiet while disabled", npulse, 0);
        wd_en = 1'b1;               // first sampled high at edge 201
        run_to(200 + BASE + 2);
        chk("R9 first request after enable", pulse_edge[0], 200 + BASE);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule